// File: doc/BRIEF.md
# Floating-Point Status Bit-Set Unit

This block holds a 32-bit floating-point status and control register and executes the single instruction that forces one chosen bit of it to 1. Each cycle it may receive a 32-bit instruction word with a valid strobe. A word that carries the right primary and extended opcodes selects one register bit through a 5-bit index field, and that bit is set. Two summary bits are protected and are only ever recomputed. After every write the sticky exception summary, the invalid-operation summary and the enabled-exception summary are brought back into agreement with the individual exception and enable bits.

Bit numbering follows the big-endian convention: bit 0 is the most significant. When the record bit of the word is 1, the unit also produces a 4-bit condition field taken from the register after the update, with a one-cycle write enable. A valid word that fails to decode raises a one-cycle no-match flag and leaves all state alone. The register and the condition field are committed on the same clock edge, one cycle after the valid word is presented. Reset is asynchronous on assertion and released through a two-stage synchronizer, so state starts to move two clock edges after `rst_n` rises.

Top module: `fpscr_setbit_unit`

## Requirements
- R1: Instruction bit n is `instr_word[31-n]`. A valid word decodes only when bits 0-5 equal 63 and bits 21-30 equal 38; otherwise `nomatch` is 1 for exactly one cycle, `cr1_we` stays 0 and `fpscr_q` is unchanged.
- R2: For a decoded word, the register bit numbered by the index in instruction bits 6-10 becomes 1; register bit n is `fpscr_q[31-n]`.
- R3: An index of 1 (enabled-exception summary) or 2 (invalid summary) performs no direct write; the register is unchanged by such a word.
- R4: When the index selects an exception bit (3-12 or 21-23) that was 0, bit 0 (sticky summary) also becomes 1; selecting any other bit leaves bit 0 unchanged.
- R5: Bit 2 always equals the OR of the invalid-operation bits 7-12 and 21-23.
- R6: Bit 1 always equals the OR of the pairs bit2&bit24, bit3&bit25, bit4&bit26, bit5&bit27 and bit6&bit28.
- R7: With the record bit (instruction bit 31) at 1, `cr1_we` pulses for one cycle and `cr1_value` equals {bit0, bit1, bit2, bit3} of the updated register, bit 0 on `cr1_value[3]`.
- R8: With the record bit at 0, `cr1_we` stays 0.
- R9: Instruction bits 11-20 are ignored: any value there decodes the same way.
- R10: Reset clears the register, `cr1_value`, `cr1_we` and `nomatch`; after reset no instruction ever clears a register bit.
- R11: Results appear on the clock edge that samples the valid word; without `instr_valid` nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction word, bit 0 of the instruction on bit 31 |
| fpscr_q | output | 32 | Status and control register, bit n on `fpscr_q[31-n]` |
| cr1_value | output | 4 | Condition field value {sticky, enabled summary, invalid summary, overflow} |
| cr1_we | output | 1 | One-cycle write enable for the condition field |
| nomatch | output | 1 | One-cycle flag for a valid word that did not decode |

## Verification
Every cycle the assertions check that both summary bits agree with the bits they summarise, that no register bit ever falls back to 0, that a written condition field matches the register's top four bits, that a rejected word or a protected index leaves the register still, and that the record bit alone decides the write enable. Only the bench scenarios show that the selected index reaches the right register position, that the sticky bit is raised only for a fresh exception bit and not for control bits, and that an enable written after its exception promotes the enabled summary. Reset values and the timing after the reset release are also shown by the directed sequences only.

// File: rtl/fpscr_pkg.sv
package fpscr_pkg;

  localparam int INSTR_W = 32;
  localparam int FP_W    = 32;
  localparam int IDX_W   = 5;
  localparam int CR_W    = 4;
  localparam int PRI_W   = 6;
  localparam int EXT_W   = 10;

  localparam logic [PRI_W-1:0] PRI_SETBIT = PRI_W'(63);
  localparam logic [EXT_W-1:0] EXT_SETBIT = EXT_W'(38);

  // big-endian bit numbers of the register
  localparam int N_FX  = 0;
  localparam int N_FEX = 1;
  localparam int N_VX  = 2;
  localparam int N_OX  = 3;
  localparam int N_UX  = 4;
  localparam int N_ZX  = 5;
  localparam int N_XX  = 6;
  localparam int N_VE  = 24;
  localparam int N_OE  = 25;
  localparam int N_UE  = 26;
  localparam int N_ZE  = 27;
  localparam int N_XE  = 28;

  // vector positions derived from the bit numbers
  localparam int P_FX  = FP_W - 1 - N_FX;
  localparam int P_FEX = FP_W - 1 - N_FEX;
  localparam int P_VX  = FP_W - 1 - N_VX;
  localparam int P_OX  = FP_W - 1 - N_OX;
  localparam int P_UX  = FP_W - 1 - N_UX;
  localparam int P_ZX  = FP_W - 1 - N_ZX;
  localparam int P_XX  = FP_W - 1 - N_XX;
  localparam int P_VE  = FP_W - 1 - N_VE;
  localparam int P_OE  = FP_W - 1 - N_OE;
  localparam int P_UE  = FP_W - 1 - N_UE;
  localparam int P_ZE  = FP_W - 1 - N_ZE;
  localparam int P_XE  = FP_W - 1 - N_XE;

  function automatic logic [FP_W-1:0] span_mask(input int lo, input int hi);
    logic [FP_W-1:0] m;
    m = '0;
    for (int n = 0; n < FP_W; n++) begin
      if (n >= lo && n <= hi) m[FP_W-1-n] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [FP_W-1:0] EXC_MASK = span_mask(3, 12) | span_mask(21, 23);
  localparam logic [FP_W-1:0] INV_MASK = span_mask(7, 12) | span_mask(21, 23);

  typedef struct packed {
    logic             hit;
    logic             bad;
    logic [IDX_W-1:0] idx;
    logic             rec;
  } setbit_dec_t;

endpackage

// File: rtl/fpscr_rst_sync.sv
module fpscr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fpscr_decode.sv
module fpscr_decode
  import fpscr_pkg::*;
(
  input  logic                    valid,
  input  logic [PRI_W-1:0]        pri_field,
  input  logic [IDX_W-1:0]        idx_field,
  input  logic [EXT_W-1:0]        ext_field,
  input  logic                    rec_field,
  output setbit_dec_t             dec
);
  logic opc_ok;

  always_comb begin
    opc_ok  = (pri_field == PRI_SETBIT) && (ext_field == EXT_SETBIT);
    dec.hit = valid && opc_ok;
    dec.bad = valid && !opc_ok;
    dec.idx = idx_field;
    dec.rec = rec_field;
  end
endmodule

// File: rtl/fpscr_next.sv
module fpscr_next
  import fpscr_pkg::*;
(
  input  logic [FP_W-1:0]  cur,
  input  logic [IDX_W-1:0] idx,
  output logic [FP_W-1:0]  nxt
);
  logic [FP_W-1:0] sel;
  logic [FP_W-1:0] raw;
  logic            fresh_exc;
  logic            vx_sum;
  logic            fex_sum;

  // one select line per register bit; the two summary bits have none
  for (genvar g = 0; g < FP_W; g++) begin : g_sel
    if (g == N_FEX || g == N_VX) begin : g_prot
      assign sel[FP_W-1-g] = 1'b0;
    end else begin : g_open
      assign sel[FP_W-1-g] = (idx == IDX_W'(g));
    end
  end

  always_comb begin
    raw       = cur | sel;
    fresh_exc = |(sel & EXC_MASK & ~cur);
    vx_sum    = |(raw & INV_MASK);
    fex_sum   = (vx_sum      & raw[P_VE]) |
                (raw[P_OX]   & raw[P_OE]) |
                (raw[P_UX]   & raw[P_UE]) |
                (raw[P_ZX]   & raw[P_ZE]) |
                (raw[P_XX]   & raw[P_XE]);
    nxt        = raw;
    nxt[P_FX]  = raw[P_FX] | fresh_exc;
    nxt[P_VX]  = vx_sum;
    nxt[P_FEX] = fex_sum;
  end
endmodule

// File: rtl/fpscr_setbit_unit.sv
module fpscr_setbit_unit
  import fpscr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr_word,
  output logic [FP_W-1:0]    fpscr_q,
  output logic [CR_W-1:0]    cr1_value,
  output logic               cr1_we,
  output logic               nomatch
);
  localparam int PRI_HI = INSTR_W - 1;
  localparam int PRI_LO = INSTR_W - PRI_W;
  localparam int IDX_HI = PRI_LO - 1;
  localparam int IDX_LO = PRI_LO - IDX_W;
  localparam int EXT_HI = EXT_W;
  localparam int EXT_LO = 1;

  logic            rst_n_sync;
  setbit_dec_t     dec;
  logic [FP_W-1:0] fpscr_d;
  logic [CR_W-1:0] cr1_d;
  logic            fpscr_en;
  logic            cr1_en;
  logic [FP_W-1:0] fpscr_r;
  logic [CR_W-1:0] cr1_r;
  logic            cr1_we_r;
  logic            nomatch_r;

  fpscr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  fpscr_decode u_dec (
    .valid     (instr_valid),
    .pri_field (instr_word[PRI_HI:PRI_LO]),
    .idx_field (instr_word[IDX_HI:IDX_LO]),
    .ext_field (instr_word[EXT_HI:EXT_LO]),
    .rec_field (instr_word[0]),
    .dec       (dec)
  );

  fpscr_next u_next (
    .cur (fpscr_r),
    .idx (dec.idx),
    .nxt (fpscr_d)
  );

  always_comb begin
    fpscr_en = dec.hit;
    cr1_en   = dec.hit && dec.rec;
    cr1_d    = {fpscr_d[P_FX], fpscr_d[P_FEX], fpscr_d[P_VX], fpscr_d[P_OX]};
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      fpscr_r   <= '0;
      cr1_r     <= '0;
      cr1_we_r  <= 1'b0;
      nomatch_r <= 1'b0;
    end else begin
      if (fpscr_en) fpscr_r <= fpscr_d;
      if (cr1_en)   cr1_r   <= cr1_d;
      cr1_we_r  <= cr1_en;
      nomatch_r <= dec.bad;
    end
  end

  assign fpscr_q   = fpscr_r;
  assign cr1_value = cr1_r;
  assign cr1_we    = cr1_we_r;
  assign nomatch   = nomatch_r;
endmodule

// File: rtl/fpscr_setbit_checker.sv
module fpscr_setbit_checker
  import fpscr_pkg::*;
(
  input logic               clk,
  input logic               rst_ok,
  input logic               instr_valid,
  input logic [INSTR_W-1:0] instr_word,
  input logic [FP_W-1:0]    fpscr_q,
  input logic [CR_W-1:0]    cr1_value,
  input logic               cr1_we,
  input logic               nomatch
);
  logic opc_ok;
  logic rsv_any;
  logic prot_idx;

  always_comb begin
    opc_ok   = (instr_word[31:26] == PRI_SETBIT) && (instr_word[10:1] == EXT_SETBIT);
    rsv_any  = |instr_word[20:11];
    prot_idx = (instr_word[25:21] == IDX_W'(N_FEX)) || (instr_word[25:21] == IDX_W'(N_VX));
  end

  assert_vx_summary_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    fpscr_q[P_VX] == |(fpscr_q & INV_MASK));

  assert_fex_summary_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    fpscr_q[P_FEX] == ((fpscr_q[P_VX] & fpscr_q[P_VE]) | (fpscr_q[P_OX] & fpscr_q[P_OE]) |
                       (fpscr_q[P_UX] & fpscr_q[P_UE]) | (fpscr_q[P_ZX] & fpscr_q[P_ZE]) |
                       (fpscr_q[P_XX] & fpscr_q[P_XE])));

  assert_never_clears_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    (fpscr_q & $past(fpscr_q)) == $past(fpscr_q));

  assert_cr_matches_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    cr1_we |-> cr1_value == {fpscr_q[P_FX], fpscr_q[P_FEX], fpscr_q[P_VX], fpscr_q[P_OX]});

  assert_record_pulse_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    (instr_valid && opc_ok && instr_word[0]) |=> cr1_we);

  assert_no_record_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    !(instr_valid && opc_ok && instr_word[0]) |=> !cr1_we);

  assert_reject_quiet_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    (instr_valid && !opc_ok) |=> (nomatch && !cr1_we && $stable(fpscr_q)));

  assert_nomatch_cause_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    !(instr_valid && !opc_ok) |=> !nomatch);

  assert_reserved_ignored_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (instr_valid && opc_ok && rsv_any) |=> !nomatch);

  assert_protected_idx_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (instr_valid && opc_ok && prot_idx) |=> $stable(fpscr_q));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    !instr_valid |=> $stable(fpscr_q));
endmodule

bind fpscr_setbit_unit fpscr_setbit_checker u_chk (
  .clk         (clk),
  .rst_ok      (rst_n_sync),
  .instr_valid (instr_valid),
  .instr_word  (instr_word),
  .fpscr_q     (fpscr_q),
  .cr1_value   (cr1_value),
  .cr1_we      (cr1_we),
  .nomatch     (nomatch)
);

// File: tb/fpscr_setbit_unit_test.sv
`timescale 1ns/1ps
module fpscr_setbit_unit_test;

  typedef struct packed {
    logic        v;
    logic [31:0] w;
    logic [31:0] f;
    logic        we;
    logic [3:0]  cr;
    logic        nm;
    logic [7:0]  req;
  } vec_t;

  function automatic logic [31:0] mk(input logic [4:0] bt, input logic rc, input logic [9:0] rsv);
    return {6'd63, bt, rsv, 10'd38, rc};
  endfunction

  localparam logic [31:0] BAD_EXT = {6'd63, 5'd0, 10'd0, 10'd39, 1'b0};
  localparam logic [31:0] BAD_PRI = {6'd62, 5'd4, 10'd0, 10'd38, 1'b1};

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    // R2, R4: control bit 13 set, no sticky summary
    '{1'b1, mk(5'd13, 1'b0, 10'd0), 32'h0004_0000, 1'b0, 4'h0, 1'b0, 8'd2},
    // R3, R7: protected index, record form
    '{1'b1, mk(5'd1,  1'b1, 10'd0), 32'h0004_0000, 1'b1, 4'h0, 1'b0, 8'd3},
    // R4: enable bit 24, no sticky summary
    '{1'b1, mk(5'd24, 1'b0, 10'd0), 32'h0004_0080, 1'b0, 4'h0, 1'b0, 8'd4},
    // R4, R5, R6, R7: invalid bit 7 with enable
    '{1'b1, mk(5'd7,  1'b1, 10'd0), 32'hE104_0080, 1'b1, 4'hE, 1'b0, 8'd5},
    // R1: wrong extended opcode
    '{1'b1, BAD_EXT,                32'hE104_0080, 1'b0, 4'h0, 1'b1, 8'd1},
    // R2, R7: overflow bit 3
    '{1'b1, mk(5'd3,  1'b1, 10'd0), 32'hF104_0080, 1'b1, 4'hF, 1'b0, 8'd7},
    // R3, R8: protected index 2, no record
    '{1'b1, mk(5'd2,  1'b0, 10'd0), 32'hF104_0080, 1'b0, 4'h0, 1'b0, 8'd8},
    // R5: invalid bit 22
    '{1'b1, mk(5'd22, 1'b0, 10'd0), 32'hF104_0280, 1'b0, 4'h0, 1'b0, 8'd5},
    // R10: sticky bit already set, direct write
    '{1'b1, mk(5'd0,  1'b1, 10'd0), 32'hF104_0280, 1'b1, 4'hF, 1'b0, 8'd10},
    // R9: reserved field all ones, bit 31
    '{1'b1, mk(5'd31, 1'b1, 10'h3FF), 32'hF104_0281, 1'b1, 4'hF, 1'b0, 8'd9},
    // R1: wrong primary opcode
    '{1'b1, BAD_PRI,                32'hF104_0281, 1'b0, 4'h0, 1'b1, 8'd1},
    // R11: decodable word without valid
    '{1'b0, mk(5'd20, 1'b1, 10'd0), 32'hF104_0281, 1'b0, 4'h0, 1'b0, 8'd11}
  };

  logic        clk;
  logic        rst_n;
  logic        instr_valid;
  logic [31:0] instr_word;
  logic [31:0] fpscr_q;
  logic [3:0]  cr1_value;
  logic        cr1_we;
  logic        nomatch;

  int checks;
  int failures;

  fpscr_setbit_unit uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .fpscr_q     (fpscr_q),
    .cr1_value   (cr1_value),
    .cr1_we      (cr1_we),
    .nomatch     (nomatch)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] ef, input logic ewe,
                       input logic [3:0] ecr, input logic enm);
    logic ok;
    checks++;
    ok = (fpscr_q == ef) && (cr1_we == ewe) && (nomatch == enm) && (!ewe || cr1_value == ecr);
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual fpscr=%h we=%b cr=%h nm=%b expected fpscr=%h we=%b cr=%h nm=%b",
               tag, fpscr_q, cr1_we, cr1_value, nomatch, ef, ewe, ecr, enm);
    end
  endtask

  task automatic issue(input logic v, input logic [31:0] w);
    instr_valid = v;
    instr_word  = w;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic do_reset();
    instr_valid = 1'b0;
    instr_word  = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    instr_valid = 1'b0;
    instr_word = '0;
    repeat (2) @(negedge clk);
    check("R10 reset held", 32'h0, 1'b0, 4'h0, 1'b0);
    do_reset();
    check("R10 after release", 32'h0, 1'b0, 4'h0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      issue(VECS[i].v, VECS[i].w);
      check($sformatf("vector %0d R%0d", i, VECS[i].req), VECS[i].f, VECS[i].we,
            VECS[i].cr, VECS[i].nm);
    end

    // R1: no-match lasts one cycle only
    @(negedge clk);
    check("R1 idle after reject", 32'hF104_0281, 1'b0, 4'h0, 1'b0);

    // R10: reset clears a populated register
    do_reset();
    check("R10 second reset", 32'h0, 1'b0, 4'h0, 1'b0);

    // R3: protected index right after reset
    issue(1'b1, mk(5'd2, 1'b1, 10'd0));
    check("R3 index 2 from zero", 32'h0, 1'b1, 4'h0, 1'b0);
    // R4, R6: inexact bit without its enable
    issue(1'b1, mk(5'd6, 1'b1, 10'd0));
    check("R4 fresh exception bit 6", 32'h8200_0000, 1'b1, 4'h8, 1'b0);
    // R6: enable written after its exception
    issue(1'b1, mk(5'd28, 1'b1, 10'd0));
    check("R6 late enable", 32'hC200_0008, 1'b1, 4'hC, 1'b0);
    // R6: exception without enable adds nothing
    issue(1'b1, mk(5'd5, 1'b1, 10'd0));
    check("R6 bit 5 without enable", 32'hC600_0008, 1'b1, 4'hC, 1'b0);
    // R11: back-to-back then idle, write enable drops
    @(negedge clk);
    check("R11 idle cycle", 32'hC600_0008, 1'b0, 4'h0, 1'b0);

    // R2, R7: direct write of bit 0 from zero
    do_reset();
    issue(1'b1, mk(5'd0, 1'b1, 10'd0));
    check("R2 bit 0 direct", 32'h8000_0000, 1'b1, 4'h8, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R11: actual running expected finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule